// File: doc/BRIEF.md
# I2C Target Controller with Host Register Port

This block lets a host processor take part on a two-wire I2C bus as an addressed target. It watches the clock and data lines and finds START and STOP conditions. It matches each address byte against a 7-bit address that the host programs, then moves one byte at a time between the bus and a single data register. After every byte it pulls the clock line low (clock stretching) and keeps it low until the host has serviced the byte. The bus therefore never outruns the software, and no byte buffer is needed.

The host reaches the block through a small synchronous register port: a word address, a write strobe, a read strobe, write data and combinational read data. Three event sources (data, START, STOP) each have a sticky raw bit, an enable mask, a masked view and a write-1-to-clear register. The interrupt output is the OR of the masked bits. Both bus inputs pass through a two-flop synchroniser and a glitch filter. The two outputs are open-drain pull-down enables.

Register words (3-bit word address): 0 own address, 1 control on write / status on read, 2 data, 3 interrupt mask, 4 raw events, 5 masked events, 6 event clear.

Top module: `i2c_target_regs`

## Requirements
- R1: An address byte is acknowledged only when its upper seven bits equal bits 6:0 of word 0. Bit 0 of the address byte selects a write transfer (0) or a read transfer (1). On a mismatch the target stays off the bus until the next START.
- R2: While bit 0 of word 1 (active) is 0, both pull outputs stay 0, and no bus event sets any raw bit.
- R3: Reading word 1 returns status: bit 0 receive pending, bit 1 transmit pending, bit 2 first byte. Receive pending and transmit pending are never 1 together.
- R4: After the eighth bit of a received byte, receive pending goes to 1, the byte can be read from word 2 and SCL is held low. A read of word 2 clears receive pending and releases SCL.
- R5: When addressed for a read transfer, and again after each acknowledged transmitted byte, transmit pending goes to 1 and SCL is held low. A write to word 2 clears it, releases SCL, and the byte is sent MSB first.
- R6: The first-byte flag is 1 only for the first byte received after the own address. It is 0 for later bytes, is cleared by the read of word 2, and is never 1 without receive pending.
- R7: While active, the target acknowledges its own address and every received byte.
- R8: A not-acknowledge from the controller after a transmitted byte ends the read transfer: transmit pending stays 0 and SCL is released.
- R9: Raw event word 4 has data in bit 0 (byte received or byte requested), START in bit 1 and STOP in bit 2. Each bit sets on its event and stays set.
- R10: Word 5 reads raw AND mask (word 3, same bit positions), and the irq output is the OR of those three bits.
- R11: Writing 1 to a bit of word 6 clears that raw bit, and writing 0 has no effect. Word 6 reads as 0. If an event and its clear land in the same cycle, the event wins.
- R12: A pulse on SDA shorter than FILT_LEN system clocks (after synchronisation) is not seen as a bus condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (side effects on word 2) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational on bus_addr |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| irq | output | 1 | OR of masked event bits |

## Verification
A raw event bit can be set by the bus and cleared by a host write to word 6 at the same clock edge. The bench provokes this with START. It first measures how many cycles pass from an SDA fall to the START raw bit, using only the register port. It then repeats the START with the clear write placed one cycle before, exactly on, and one cycle after that edge. The bit must still be set in the first two cases and cleared in the third.

// File: rtl/i2ct_pkg.sv
// Shared constants and types for the I2C target controller.
// Assumes a 3-bit word address on the host register port.
package i2ct_pkg;
    localparam int REG_AW  = 3;
    localparam int BYTE_W  = 8;
    localparam int TADDR_W = 7;
    localparam int NUM_EV  = 3;
    localparam int EV_DATA  = 0;
    localparam int EV_START = 1;
    localparam int EV_STOP  = 2;

    localparam logic [REG_AW-1:0] RW_OWN  = 3'd0;
    localparam logic [REG_AW-1:0] RW_CTL  = 3'd1;
    localparam logic [REG_AW-1:0] RW_DATA = 3'd2;
    localparam logic [REG_AW-1:0] RW_MASK = 3'd3;
    localparam logic [REG_AW-1:0] RW_RAW  = 3'd4;
    localparam logic [REG_AW-1:0] RW_MSK  = 3'd5;
    localparam logic [REG_AW-1:0] RW_CLR  = 3'd6;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_HOLD,
        ST_RX_ACK, ST_TX_HOLD, ST_TX, ST_TX_ACK
    } eng_state_e;
endpackage

// File: rtl/i2ct_line_filter.sv
// Two-flop synchroniser plus a run-length glitch filter for one bus line.
// The clean output follows the synchronised level only after FILT_LEN
// consecutive samples differ from it. Assumes an idle-high line.
module i2ct_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] run_cnt;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= pin_i;
            s2 <= s1;
        end
    end

    // Accept a new level only after it has persisted FILT_LEN samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_o <= 1'b1;
            run_cnt <= '0;
        end else if (s2 == clean_o) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_LEN - 1)) begin
            clean_o <= s2;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2ct_engine.sv
// Bus protocol engine: START/STOP detection, address match, byte shifting,
// acknowledge handling and clock stretching. Works on filtered line levels.
// Assumes the host register block supplies one-cycle read/write strobes.
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [TADDR_W-1:0] own_addr,
    input  logic               scl_f,
    input  logic               sda_f,
    input  logic               data_rd,
    input  logic               data_wr,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               rreq,
    output logic               treq,
    output logic               fbr,
    output logic               ev_start,
    output logic               ev_stop,
    output logic               ev_data,
    output logic               scl_low,
    output logic               sda_low
);
    eng_state_e        state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              scl_p, sda_p, rw_q, first_q, nack_q;
    logic              scl_rise, scl_fall;

    assign scl_rise = scl_f & ~scl_p;
    assign scl_fall = ~scl_f & scl_p;
    assign ev_start = active & scl_f & scl_p & sda_p & ~sda_f;
    assign ev_stop  = active & scl_f & scl_p & ~sda_p & sda_f;

    assign rreq    = (state == ST_RX_HOLD);
    assign treq    = (state == ST_TX_HOLD);
    assign scl_low = rreq | treq;
    assign sda_low = (state == ST_ADDR_ACK) | (state == ST_RX_HOLD) |
                     (state == ST_RX_ACK) | ((state == ST_TX) & ~shreg[BYTE_W-1]);

    // Previous filtered levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    // Transfer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            rx_byte <= '0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            nack_q  <= 1'b0;
            fbr     <= 1'b0;
            ev_data <= 1'b0;
        end else begin
            ev_data <= 1'b0;
            if (!active) begin
                state <= ST_IDLE;
                fbr   <= 1'b0;
            end else if (ev_start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                fbr    <= 1'b0;
            end else if (ev_stop) begin
                state <= ST_IDLE;
                fbr   <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_f};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (state == ST_RX) begin
                                state   <= ST_RX_HOLD;
                                rx_byte <= shreg;
                                fbr     <= first_q;
                                first_q <= 1'b0;
                                ev_data <= 1'b1;
                            end else if (shreg[BYTE_W-1:1] == own_addr) begin
                                state <= ST_ADDR_ACK;
                                rw_q  <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        if (rw_q) begin
                            state   <= ST_TX_HOLD;
                            ev_data <= 1'b1;
                        end else begin
                            state   <= ST_RX;
                            bitcnt  <= '0;
                            first_q <= 1'b1;
                        end
                    end
                    ST_RX_HOLD: if (data_rd) begin
                        state <= ST_RX_ACK;
                        fbr   <= 1'b0;
                    end
                    ST_RX_ACK: if (scl_fall) begin
                        state  <= ST_RX;
                        bitcnt <= '0;
                    end
                    ST_TX_HOLD: if (data_wr) begin
                        shreg  <= wdata;
                        bitcnt <= '0;
                        state  <= ST_TX;
                    end
                    ST_TX: if (scl_fall) begin
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) state <= ST_TX_ACK;
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) nack_q <= sda_f;
                        if (scl_fall) begin
                            if (!nack_q) begin
                                state   <= ST_TX_HOLD;
                                ev_data <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active) |-> (!scl_low && !sda_low)); // R2
    AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rreq && data_rd && active && !ev_start && !ev_stop) |=> !rreq); // R4
    AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (treq && data_wr && active && !ev_start && !ev_stop) |=> !treq); // R5
    AST_FBR_ONLY_RX: assert property (@(posedge clk) disable iff (!rst_n)
        fbr |-> rreq); // R6
endmodule

// File: rtl/i2ct_regs.sv
// Host register block: own address, control/status, data, and the
// raw/mask/masked/clear event scheme driving irq. Read data is
// combinational on the address. Assumes single-cycle strobes.
module i2ct_regs
    import i2ct_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    input  logic               rreq,
    input  logic               treq,
    input  logic               fbr,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic               ev_start,
    input  logic               ev_stop,
    input  logic               ev_data,
    output logic [TADDR_W-1:0] own_addr,
    output logic               active,
    output logic               data_rd,
    output logic               data_wr,
    output logic               irq
);
    logic [NUM_EV-1:0] raw_q, mask_q, ev_set, ev_clr, masked;

    assign data_rd = bus_re & (bus_addr == RW_DATA);
    assign data_wr = bus_we & (bus_addr == RW_DATA);

    always_comb begin
        ev_set           = '0;
        ev_set[EV_DATA]  = ev_data;
        ev_set[EV_START] = ev_start;
        ev_set[EV_STOP]  = ev_stop;
    end
    assign ev_clr = (bus_we && bus_addr == RW_CLR) ? bus_wdata[NUM_EV-1:0] : '0;
    assign masked = raw_q & mask_q;
    assign irq    = |masked;

    // Configuration registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_addr <= '0;
            active   <= 1'b0;
            mask_q   <= '0;
        end else if (bus_we) begin
            if (bus_addr == RW_OWN)  own_addr <= bus_wdata[TADDR_W-1:0];
            if (bus_addr == RW_CTL)  active   <= bus_wdata[0];
            if (bus_addr == RW_MASK) mask_q   <= bus_wdata[NUM_EV-1:0];
        end
    end

    // Sticky raw events; a new event beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~ev_clr) | ev_set;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RW_OWN:  bus_rdata[TADDR_W-1:0] = own_addr;
            RW_CTL:  bus_rdata[2:0]         = {fbr, treq, rreq};
            RW_DATA: bus_rdata              = rx_byte;
            RW_MASK: bus_rdata[NUM_EV-1:0]  = mask_q;
            RW_RAW:  bus_rdata[NUM_EV-1:0]  = raw_q;
            RW_MSK:  bus_rdata[NUM_EV-1:0]  = masked;
            default: bus_rdata = '0;
        endcase
    end

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rreq && treq)); // R3
    AST_DATA_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rreq) |=> raw_q[EV_DATA]); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> raw_q[EV_START]); // R11
    AST_CLR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RW_CLR && bus_wdata[EV_STOP] && !ev_stop) |=> !raw_q[EV_STOP]); // R11
endmodule

// File: rtl/i2c_target_regs.sv
// Top level: filters both bus lines, runs the protocol engine and exposes
// the host register port. Bus outputs are open-drain pull-down enables.
module i2c_target_regs
    import i2ct_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              irq
);
    logic [1:0]         pins, clean;
    logic [TADDR_W-1:0] own_addr;
    logic [BYTE_W-1:0]  rx_byte;
    logic active, data_rd, data_wr, rreq, treq, fbr;
    logic ev_start, ev_stop, ev_data;

    assign pins = {scl_in, sda_in};

    // One synchroniser and filter per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_line
        i2ct_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .pin_i(pins[g]), .clean_o(clean[g]));
    end

    i2ct_engine u_eng (
        .clk(clk), .rst_n(rst_n), .active(active), .own_addr(own_addr),
        .scl_f(clean[1]), .sda_f(clean[0]), .data_rd(data_rd),
        .data_wr(data_wr), .wdata(bus_wdata), .rx_byte(rx_byte),
        .rreq(rreq), .treq(treq), .fbr(fbr), .ev_start(ev_start),
        .ev_stop(ev_stop), .ev_data(ev_data), .scl_low(scl_pull),
        .sda_low(sda_pull));

    i2ct_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rreq(rreq), .treq(treq), .fbr(fbr), .rx_byte(rx_byte),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_data(ev_data),
        .own_addr(own_addr), .active(active), .data_rd(data_rd),
        .data_wr(data_wr), .irq(irq));
endmodule

// File: tb/sim_i2c_target_regs.sv
`timescale 1ns/1ps
module sim_i2c_target_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd4;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic scl_pull, sda_pull, irq;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    wire  scl_line = !(m_scl_low | scl_pull);
    wire  sda_line = !(m_sda_low | sda_pull);

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;
    // Behavioural model state for per-clock comparison.
    bit       mdl_active = 1'b0;
    bit [2:0] mdl_mask = 3'b000;
    localparam int Q = 10;

    always #2.5 clk = ~clk;

    i2c_target_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scl_in(scl_line), .sda_in(sda_line), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .irq(irq));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            if (!mdl_active)
                chk(!scl_pull && !sda_pull, "R2 idle pulls", {scl_pull, sda_pull}, 0);
            if (!bus_we && !bus_re && bus_addr == 3'd4)
                chk(irq == |(bus_rdata[2:0] & mdl_mask), "R10 irq", irq, |(bus_rdata[2:0] & mdl_mask));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = 3'd4;
        if (a == 3'd1) mdl_active = d[0];
        if (a == 3'd3) mdl_mask = d[2:0];
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0; bus_addr = 3'd4;
    endtask

    task automatic m_clock(output bit s);
        m_scl_low = 1'b0;
        while (!scl_line) cyc(1);
        cyc(Q);
        s = sda_line;
        cyc(Q);
        m_scl_low = 1'b1;
        cyc(Q);
    endtask

    task automatic m_start();
        m_sda_low = 1'b1; cyc(Q);
        m_scl_low = 1'b1; cyc(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; cyc(Q);
        m_scl_low = 1'b0;
        while (!scl_line) cyc(1);
        cyc(Q);
        m_sda_low = 1'b0; cyc(2 * Q);
    endtask

    task automatic m_write_byte(input logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i];
            cyc(Q);
            m_clock(s);
        end
        m_sda_low = 1'b0;
    endtask

    task automatic m_get_ack(output bit ack);
        bit s;
        m_sda_low = 1'b0; cyc(Q);
        m_clock(s);
        ack = !s;
    endtask

    task automatic m_read_byte(output logic [7:0] b);
        bit s;
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            cyc(Q);
            m_clock(s);
            b[i] = s;
        end
    endtask

    task automatic m_give_ack(input bit ack);
        bit s;
        m_sda_low = ack; cyc(Q);
        m_clock(s);
        m_sda_low = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            finished = 1'b1;
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit ack;
        int n_set;
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        // Reset state.
        rd(3'd1, d); chk(d == 8'h00, "R3 reset status", d, 0);
        rd(3'd4, d); chk(d == 8'h00, "R9 reset raw", d, 0);
        chk(irq == 1'b0, "R10 reset irq", irq, 0);

        wr(3'd0, 8'h2A);
        wr(3'd1, 8'h01);
        wr(3'd3, 8'h07);

        // Write transfer: two bytes.
        m_start();
        m_write_byte(8'h54);
        m_get_ack(ack); chk(ack, "R1 own address acked", ack, 1);
        rd(3'd4, d); chk(d[1] == 1'b1, "R9 start raw", d, 2);
        m_write_byte(8'hA5);
        cyc(30);
        chk(scl_pull == 1'b1, "R4 stretch rx", scl_pull, 1);
        rd(3'd1, d); chk(d[2:0] == 3'b101, "R6 first byte status", d, 5);
        rd(3'd5, d); chk(d[2:0] == 3'b011, "R10 masked view", d, 3);
        rd(3'd2, d); chk(d == 8'hA5, "R4 rx data", d, 8'hA5);
        rd(3'd1, d); chk(d[2:0] == 3'b000, "R4 read clears", d, 0);
        m_get_ack(ack); chk(ack, "R7 data acked", ack, 1);
        m_write_byte(8'h3C);
        cyc(30);
        rd(3'd1, d); chk(d[2:0] == 3'b001, "R6 later byte flag", d, 1);
        rd(3'd2, d); chk(d == 8'h3C, "R4 second byte", d, 8'h3C);
        m_get_ack(ack); chk(ack, "R7 second ack", ack, 1);
        m_stop();
        rd(3'd4, d); chk(d[2:0] == 3'b111, "R9 stop raw", d, 7);
        wr(3'd6, 8'h00);
        rd(3'd4, d); chk(d[2:0] == 3'b111, "R11 zero clear", d, 7);
        rd(3'd6, d); chk(d == 8'h00, "R11 clear reads zero", d, 0);
        wr(3'd6, 8'h07);
        rd(3'd4, d); chk(d[2:0] == 3'b000, "R11 clear all", d, 0);

        // Read transfer: two bytes, NACK ends it.
        m_start();
        m_write_byte(8'h55);
        m_get_ack(ack); chk(ack, "R1 read address acked", ack, 1);
        cyc(30);
        rd(3'd1, d); chk(d[2:0] == 3'b010, "R5 tx pending", d, 2);
        chk(scl_pull == 1'b1, "R5 stretch tx", scl_pull, 1);
        wr(3'd2, 8'hC3);
        m_read_byte(d); chk(d == 8'hC3, "R5 tx byte", d, 8'hC3);
        m_give_ack(1'b1);
        cyc(30);
        rd(3'd1, d); chk(d[2:0] == 3'b010, "R5 tx pending again", d, 2);
        wr(3'd2, 8'h5A);
        m_read_byte(d); chk(d == 8'h5A, "R5 second tx byte", d, 8'h5A);
        m_give_ack(1'b0);
        cyc(30);
        rd(3'd1, d); chk(d[2:0] == 3'b000, "R8 nack no request", d, 0);
        chk(scl_pull == 1'b0, "R8 scl released", scl_pull, 0);
        m_stop();

        // Address mismatch.
        m_start();
        m_write_byte(8'h56);
        m_get_ack(ack); chk(!ack, "R1 mismatch not acked", ack, 0);
        rd(3'd1, d); chk(d[2:0] == 3'b000, "R1 mismatch status", d, 0);
        m_stop();

        // Mask behaviour.
        wr(3'd3, 8'h00); cyc(2);
        chk(irq == 1'b0, "R10 fully masked", irq, 0);
        wr(3'd3, 8'h04); cyc(2);
        chk(irq == 1'b1, "R10 stop unmasked", irq, 1);
        wr(3'd3, 8'h07);

        // Inactive target.
        wr(3'd1, 8'h00);
        wr(3'd6, 8'h07);
        m_start();
        m_write_byte(8'h54);
        m_get_ack(ack); chk(!ack, "R2 inactive no ack", ack, 0);
        m_stop();
        rd(3'd4, d); chk(d[2:0] == 3'b000, "R2 inactive no events", d, 0);
        wr(3'd1, 8'h01);

        // Glitch on SDA while SCL is high.
        wr(3'd6, 8'h07);
        @(posedge clk); #1 m_sda_low = 1'b1;
        @(posedge clk); @(posedge clk); #1 m_sda_low = 1'b0;
        cyc(20);
        rd(3'd4, d); chk(d[2:0] == 3'b000, "R12 glitch ignored", d, 0);

        // Calibrate START latency at the port.
        n_set = 0;
        bus_addr = 3'd4;
        @(posedge clk); #1 m_sda_low = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (n_set == 0 && bus_rdata[1]) n_set = i;
        end
        chk(n_set > 0, "R9 start seen", n_set, 1);
        m_sda_low = 1'b0; cyc(20);

        // Clear write before, on, and after the START set edge.
        for (int k = n_set - 1; k <= n_set + 1; k++) begin
            wr(3'd6, 8'h07);
            cyc(5);
            @(posedge clk); #1 m_sda_low = 1'b1;
            for (int j = 1; j < k; j++) @(posedge clk);
            #1;
            bus_addr = 3'd6; bus_wdata = 8'h02; bus_we = 1'b1;
            @(posedge clk); #1;
            bus_we = 1'b0; bus_addr = 3'd4;
            cyc(3);
            rd(3'd4, d);
            chk(d[1] == (k <= n_set), "R11 clear vs start same edge", d[1], (k <= n_set));
            m_sda_low = 1'b0; cyc(20);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule